// File: doc/BRIEF.md
# Flash Power-State Controller with Access Stall

This block owns the single power level shared by a flash/OTP memory bank and its charge pump. The level is one of three: sleep (lowest power, entered on reset), standby (intermediate) and active (highest power, the only level in which reads are served). Software selects a level through a 2-bit mode write port. A CPU read or instruction fetch to the memory region raises the level to active on its own.

Moving down is immediate. Moving up goes one level at a time, and each step waits out a programmable settle delay. While the bank is climbing toward active, or counting the read wait states once it is there, the controller holds the CPU stall line high. It releases the access in the cycle that the wait-state count completes. The flash and OTP regions each have their own wait-state count.

A lower-level write that arrives in the middle of a climb cancels the climb. The new level takes effect at once.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: After a synchronous reset the level is sleep (`pwr_mode` = 2'b00), no settle is running, and `acc_stall` and `acc_done` are low.
- R2: Level codes are 2'b00 sleep, 2'b01 standby and 2'b11 active. A written 2'b10 is taken as active. `pwr_mode` always shows the settled level, never 2'b10, and this one value drives both bank and pump.
- R3: With an access held from sleep, the level becomes standby `dly_sleep_stby`+1 cycles after the first edge that samples the request. The standby-to-active settle starts at the next edge, and the level becomes active `dly_stby_act`+1 cycles after that edge.
- R4: With an access held from standby, the level becomes active `dly_stby_act`+1 cycles after the first edge that samples the request.
- R5: A mode write whose level is at or below the current level sets `pwr_mode` to that level at the next edge. It also cancels any settle in progress.
- R6: A mode write above the current level starts the climb with the same per-step settle delays, without needing any access.
- R7: An access that arrives while the level is below active, including during a settle, keeps `acc_stall` high and `acc_done` low until the level is active.
- R8: In active, an access completes (`acc_done`=1, `acc_stall`=0) in the cycle in which the number of stalled active cycles already spent on it equals `ws_otp` when `acc_otp`=1, or `ws_flash` otherwise. Before that cycle `acc_stall`=1.
- R9: `acc_done` is never high unless the level is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr_en | input | 1 | Write strobe for the power-mode field |
| mode_wr_data | input | 2 | Requested level code |
| dly_sleep_stby | input | CNT_W | Settle count for the sleep-to-standby step |
| dly_stby_act | input | CNT_W | Settle count for the standby-to-active step |
| ws_flash | input | WS_W | Wait states for flash-region reads |
| ws_otp | input | WS_W | Wait states for OTP-region reads |
| acc_req | input | 1 | CPU read/fetch to the memory region, held until done |
| acc_otp | input | 1 | The access targets the OTP region |
| acc_stall | output | 1 | Stall to the CPU |
| acc_done | output | 1 | Access completes in this cycle |
| pwr_mode | output | 2 | Settled level, shared by bank and pump |

## Verification
A wrong level register shows on `pwr_mode` at the very next edge. It also shows in the cycle at which `acc_done` first rises, so a lost or extra settle cycle moves the release of the stall by exactly that amount.

A settle that is cancelled in the wrong way leaves the level climbing after a lower write, which is visible within one cycle. A wrong wait-state counter or region select shifts `acc_done` within a single access. Comparing every output on every cycle against a behavioural model places each such fault at the cycle where it first appears.

// File: rtl/flash_pwr_pkg.sv
// Shared level codes and helpers for the flash power-state controller.
// Assumes the codes are ordered so that an unsigned compare ranks power.
package flash_pwr_pkg;

    typedef enum logic [1:0] {
        LVL_SLEEP  = 2'b00,
        LVL_STBY   = 2'b01,
        LVL_ACTIVE = 2'b11
    } pwr_lvl_e;

    // Map a raw written code onto a legal level (10 is taken as active).
    function automatic pwr_lvl_e lvl_of(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_SLEEP;
            2'b01:   return LVL_STBY;
            default: return LVL_ACTIVE;
        endcase
    endfunction

    // Level reached by one upward step from the given level.
    function automatic pwr_lvl_e step_up(input pwr_lvl_e cur);
        return (cur == LVL_SLEEP) ? LVL_STBY : LVL_ACTIVE;
    endfunction

endpackage

// File: rtl/flash_settle_timer.sv
// Down-counter that times one upward settle step.
// Assumes load and clear are never both relevant: clear wins.
module flash_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    output logic             running,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Count the settle window down while a step is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (clear) begin
            running <= 1'b0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= load_val;
        end else if (running) begin
            cnt     <= cnt - 1'b1;
        end
    end

    // Step is complete in the cycle the count has drained.
    assign expired = running && (cnt == '0);

    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !expired && !clear) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/flash_pwr_fsm.sv
// Level register, goal tracking and step sequencing for the bank and pump.
// Assumes acc_req is held by the CPU until the access completes.
module flash_pwr_fsm
    import flash_pwr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr_en,
    input  logic [1:0]       mode_wr_data,
    input  logic             acc_req,
    input  logic [CNT_W-1:0] dly_sleep_stby,
    input  logic [CNT_W-1:0] dly_stby_act,
    input  logic             t_running,
    input  logic             t_expired,
    output logic             t_load,
    output logic [CNT_W-1:0] t_load_val,
    output logic             t_clear,
    output pwr_lvl_e         cur_lvl
);
    pwr_lvl_e goal_q;
    pwr_lvl_e eff_goal;
    pwr_lvl_e wr_lvl;
    logic     lower_wr;
    logic     chk_armed;

    // Decode the write and the goal an access imposes.
    always_comb begin
        wr_lvl   = lvl_of(mode_wr_data);
        lower_wr = mode_wr_en && (wr_lvl <= cur_lvl);
        eff_goal = acc_req ? LVL_ACTIVE : goal_q;
    end

    // Drive the settle timer: start a step when below goal, stop on expiry or lower write.
    always_comb begin
        t_clear    = lower_wr || t_expired;
        t_load     = !lower_wr && !t_running && (cur_lvl < eff_goal);
        t_load_val = (cur_lvl == LVL_SLEEP) ? dly_sleep_stby : dly_stby_act;
    end

    // Hold the settled level: drop at once on a lower write, rise one step on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lvl <= LVL_SLEEP;
        end else if (lower_wr) begin
            cur_lvl <= wr_lvl;
        end else if (t_expired) begin
            cur_lvl <= step_up(cur_lvl);
        end
    end

    // Remember the last software-requested level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            goal_q <= LVL_SLEEP;
        end else if (mode_wr_en) begin
            goal_q <= wr_lvl;
        end
    end

    // Arm history-based checks one cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    a_r2_legal_level: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lvl != 2'b10);

    a_r5_lower_write_now: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_en && (lvl_of(mode_wr_data) <= cur_lvl))
            |=> (cur_lvl == lvl_of($past(mode_wr_data)) && !t_running));

    a_r3_single_step_up: assert property (@(posedge clk) disable iff (!rst_n || !chk_armed)
        (cur_lvl > $past(cur_lvl)) |-> (cur_lvl == step_up($past(cur_lvl))));

    a_r1_reset_sleep: assert property (@(posedge clk)
        !rst_n |=> (cur_lvl == LVL_SLEEP));

endmodule

// File: rtl/flash_wait_gate.sv
// Counts read wait states in the active level and produces stall/done.
// Assumes the access is held until done and the level is registered upstream.
module flash_wait_gate
    import flash_pwr_pkg::*;
#(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pwr_lvl_e        cur_lvl,
    input  logic            t_running,
    input  logic            acc_req,
    input  logic            acc_otp,
    input  logic [WS_W-1:0] ws_flash,
    input  logic [WS_W-1:0] ws_otp,
    output logic            acc_stall,
    output logic            acc_done
);
    logic [WS_W-1:0] ws_cnt;
    logic [WS_W-1:0] ws_sel;
    logic            serving;

    // Select the region's wait count and decide completion.
    always_comb begin
        ws_sel    = acc_otp ? ws_otp : ws_flash;
        serving   = acc_req && (cur_lvl == LVL_ACTIVE);
        acc_done  = serving && (ws_cnt == ws_sel);
        acc_stall = acc_req && !acc_done;
    end

    // Count stalled active cycles of the current access.
    always_ff @(posedge clk) begin
        if (!rst_n || !serving || acc_done) ws_cnt <= '0;
        else                                ws_cnt <= ws_cnt + 1'b1;
    end

    a_r9_done_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> (cur_lvl == LVL_ACTIVE));

    a_r7_no_done_while_settling: assert property (@(posedge clk) disable iff (!rst_n)
        t_running |-> !acc_done);

    a_r8_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stall |-> acc_req);

endmodule

// File: rtl/flash_pwr_ctrl.sv
// Top of the flash power-state controller: level FSM, settle timer, wait gate.
// Assumes one shared level for bank and pump and a CPU that holds acc_req.
module flash_pwr_ctrl
    import flash_pwr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int WS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr_en,
    input  logic [1:0]       mode_wr_data,
    input  logic [CNT_W-1:0] dly_sleep_stby,
    input  logic [CNT_W-1:0] dly_stby_act,
    input  logic [WS_W-1:0]  ws_flash,
    input  logic [WS_W-1:0]  ws_otp,
    input  logic             acc_req,
    input  logic             acc_otp,
    output logic             acc_stall,
    output logic             acc_done,
    output logic [1:0]       pwr_mode
);
    pwr_lvl_e         cur_lvl;
    logic             t_load;
    logic             t_clear;
    logic             t_running;
    logic             t_expired;
    logic [CNT_W-1:0] t_load_val;

    flash_pwr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_wr_en     (mode_wr_en),
        .mode_wr_data   (mode_wr_data),
        .acc_req        (acc_req),
        .dly_sleep_stby (dly_sleep_stby),
        .dly_stby_act   (dly_stby_act),
        .t_running      (t_running),
        .t_expired      (t_expired),
        .t_load         (t_load),
        .t_load_val     (t_load_val),
        .t_clear        (t_clear),
        .cur_lvl        (cur_lvl)
    );

    flash_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_load_val),
        .clear    (t_clear),
        .running  (t_running),
        .expired  (t_expired)
    );

    flash_wait_gate #(.WS_W(WS_W)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_lvl   (cur_lvl),
        .t_running (t_running),
        .acc_req   (acc_req),
        .acc_otp   (acc_otp),
        .ws_flash  (ws_flash),
        .ws_otp    (ws_otp),
        .acc_stall (acc_stall),
        .acc_done  (acc_done)
    );

    // One level value drives both bank and pump and is what software reads.
    assign pwr_mode = cur_lvl;

endmodule

// File: tb/flash_pwr_ctrl_tb.sv
// Cycle-by-cycle behavioural model compared against the controller on every clock.
module flash_pwr_ctrl_tb;
    localparam int CNT_W = 8;
    localparam int WS_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_wr_en = 1'b0;
    logic [1:0]       mode_wr_data = 2'b00;
    logic [CNT_W-1:0] dly_sleep_stby = 8'd5;
    logic [CNT_W-1:0] dly_stby_act = 8'd2;
    logic [WS_W-1:0]  ws_flash = 4'd2;
    logic [WS_W-1:0]  ws_otp = 4'd3;
    logic             acc_req = 1'b0;
    logic             acc_otp = 1'b0;
    logic             acc_stall;
    logic             acc_done;
    logic [1:0]       pwr_mode;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    int m_cur = 0, m_goal = 0, m_tmr = 0, m_cnt = 0;
    bit m_run = 0;
    bit last_done = 0;

    always #10 clk = ~clk;

    flash_pwr_ctrl #(.CNT_W(CNT_W), .WS_W(WS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .dly_sleep_stby(dly_sleep_stby), .dly_stby_act(dly_stby_act),
        .ws_flash(ws_flash), .ws_otp(ws_otp), .acc_req(acc_req), .acc_otp(acc_otp),
        .acc_stall(acc_stall), .acc_done(acc_done), .pwr_mode(pwr_mode)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, compare before posedge, advance the model.
    task automatic cyc(input bit req, input bit otp, input bit wen, input logic [1:0] wd, input string tag);
        int ws, lvl, geff;
        bit e_act, e_done, e_stall, lower, expd;
        acc_req = req; acc_otp = otp; mode_wr_en = wen; mode_wr_data = wd;
        #5;
        e_act   = (m_cur == 3);
        ws      = otp ? int'(ws_otp) : int'(ws_flash);
        e_done  = req && e_act && (m_cnt == ws);
        e_stall = req && !e_done;
        check(tag, "pwr_mode", int'(pwr_mode), m_cur);
        check(tag, "acc_stall", int'(acc_stall), int'(e_stall));
        check(tag, "acc_done", int'(acc_done), int'(e_done));
        last_done = e_done;
        lvl   = (wd == 2'b00) ? 0 : (wd == 2'b01) ? 1 : 3;
        lower = wen && (lvl <= m_cur);
        geff  = req ? 3 : m_goal;
        expd  = m_run && (m_tmr == 0);
        m_cnt = (!(req && e_act) || e_done) ? 0 : m_cnt + 1;
        if (lower || expd) m_run = 0;
        else if (!m_run && m_cur < geff) begin
            m_run = 1;
            m_tmr = (m_cur == 0) ? int'(dly_sleep_stby) : int'(dly_stby_act);
        end else if (m_run) m_tmr--;
        if (lower) m_cur = lvl;
        else if (expd) m_cur = (m_cur == 0) ? 1 : 3;
        if (wen) m_goal = lvl;
        @(negedge clk);
    endtask

    task automatic access(input bit otp, input string tag);
        for (int i = 0; i < 100; i++) begin
            cyc(1'b1, otp, 1'b0, 2'b00, tag);
            if (last_done) break;
        end
        cyc(1'b0, 1'b0, 1'b0, 2'b00, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 2'b00, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle(2, "R1");
        // R3 / R7: access from sleep climbs two steps, stalled throughout, flash wait states R8
        access(1'b0, "R3");
        access(1'b0, "R8");
        access(1'b1, "R8");
        // R5: write lower from active takes effect at once
        cyc(1'b0, 1'b0, 1'b1, 2'b01, "R5");
        idle(2, "R5");
        // R4: access from standby, OTP region
        access(1'b1, "R4");
        // R5: drop to sleep, then R6 write higher (10 = active, R2) and abort mid-climb
        cyc(1'b0, 1'b0, 1'b1, 2'b00, "R5");
        cyc(1'b0, 1'b0, 1'b1, 2'b10, "R6");
        idle(3, "R6");
        cyc(1'b0, 1'b0, 1'b1, 2'b00, "R5");
        idle(8, "R5");
        // R6: write standby, full settle without access
        cyc(1'b0, 1'b0, 1'b1, 2'b01, "R6");
        idle(8, "R6");
        // R2: write 10 from standby climbs to active
        cyc(1'b0, 1'b0, 1'b1, 2'b10, "R2");
        idle(5, "R2");
        // R5: equal-level write keeps active
        cyc(1'b0, 1'b0, 1'b1, 2'b11, "R5");
        idle(1, "R5");
        // R7: access arriving during a settle from sleep, zero delays and zero wait states
        cyc(1'b0, 1'b0, 1'b1, 2'b00, "R7");
        dly_sleep_stby = 8'd0; dly_stby_act = 8'd0; ws_flash = 4'd0;
        cyc(1'b0, 1'b0, 1'b1, 2'b01, "R7");
        access(1'b0, "R7");
        access(1'b0, "R8");
        // R9: lower write while an access is pending restarts the climb
        cyc(1'b0, 1'b0, 1'b1, 2'b00, "R9");
        dly_sleep_stby = 8'd3; dly_stby_act = 8'd4; ws_otp = 4'd1;
        cyc(1'b1, 1'b1, 1'b0, 2'b00, "R9");
        cyc(1'b1, 1'b1, 1'b0, 2'b00, "R9");
        cyc(1'b1, 1'b1, 1'b1, 2'b00, "R9");
        access(1'b1, "R9");
        idle(2, "R1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule